// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for clause-22 management frames on a two-wire MDC/MDIO bus. Software first sets up the MDC clock divider and the preamble option in a control register. It then writes a single 32-bit command word. That word packs the opcode, the PHY address, the register address, the turnaround code and, for writes, the 16-bit data.

The write starts a complete frame. The word's fields already sit in the order they travel on the wire, so the frame is shifted out most significant bit first. For a read frame the master releases the line for the turnaround and the data bits. It samples the 16 bits the PHY returns into the low half of the same command register.

When the frame ends, a sticky completion flag is raised. The flag also drives the interrupt pin, and software clears it by writing one to it. While a frame is running, any further command write is dropped.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, mdc, mdio_oe and irq are low, and every register reads as zero.
- R2: Register offsets are 0 (control: bits 6:0 MDC divider D, bit 7 preamble enable), 1 (command/data) and 2 (status: bit 0 completion flag). Other offsets read zero. Control and command read back what was written.
- R3: A write to offset 1 while idle starts a frame. The command's field layout is data 15:0, turnaround 17:16, register 22:18, PHY 27:23 and opcode 31:28. After the optional preamble, frame bit p (p = 0..31) carries command bit 31-p. So opcode bits 31:30 form the start field and bits 29:28 form the operation field.
- R4: With control bit 7 set, 32 one bits precede the frame, giving 64 MDC periods instead of 32.
- R5: Each MDC half period lasts D+1 clocks, with mdc low first. mdio_o changes only while mdc falls and is stable while mdc is high. The completion flag is set exactly 2·N·(D+1) clocks after the command write edge, where N is 32 or 64.
- R6: A read frame is one whose command bits 29:28 are 2'b10 (opcode 0x6). In a read frame mdio_oe is low during frame bits 14..31. mdio_i is sampled on the rising MDC edges of frame bits 16..31 into command bits 15..0, MSB first. Bits 31:16 are kept.
- R7: In any other frame (for example opcode 0x5, a write), mdio_oe is high for every bit.
- R8: The completion flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R9: Between frames mdc is low and mdio_oe is low.
- R10: A command write during a frame is ignored: the frame on the wire and the command register are unchanged.
- R11: The irq output equals the completion flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| irq | output | 1 | Completion interrupt |

## Verification
The completion flag is due exactly 2·N·(D+1) clocks after the clock edge that captures the command write. The bench counts falling clock edges from that edge until irq appears and compares the count with that formula. Bit values and drive state are captured on each rising MDC edge, half an MDC period after they change and half before they may change again. The PHY model updates mdio_i on falling MDC edges, so the master's sample on the rising edge sees a settled value. Register readback and idle state are checked at a falling clock edge after the flag appears, when the final register updates are already visible.

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  localparam int PRE_LEN = 32;
  localparam int FRM_LEN = 32;
  localparam int IW      = $clog2(PRE_LEN + FRM_LEN) + 1;
  localparam int TA_POS  = 14;
  localparam int DAT_POS = 16;

  logic [DIV_W-1:0] div_q, cnt;
  logic             pre_q, fpre, fread, busy, mdc_q, out_q, oe_q, irq_q;
  logic [31:0]      cmd;
  logic [IW-1:0]    bidx, nidx, last_idx, cpos, npos;
  logic             cpre, npre, nval, ndrv, csamp, half_end;

  wire wr_ctl = reg_we && reg_addr == 2'd0;
  wire wr_cmd = reg_we && reg_addr == 2'd1;
  wire wr_sts = reg_we && reg_addr == 2'd2;

  assign last_idx = fpre ? IW'(PRE_LEN + FRM_LEN - 1) : IW'(FRM_LEN - 1);
  assign nidx     = bidx + 1'b1;
  assign cpre     = fpre && bidx < IW'(PRE_LEN);
  assign npre     = fpre && nidx < IW'(PRE_LEN);
  assign cpos     = fpre ? bidx - IW'(PRE_LEN) : bidx;
  assign npos     = fpre ? nidx - IW'(PRE_LEN) : nidx;
  assign nval     = npre ? 1'b1 : cmd[5'd31 - npos[4:0]];
  assign ndrv     = npre || !(fread && npos >= IW'(TA_POS));
  assign csamp    = fread && !cpre && cpos >= IW'(DAT_POS);
  assign half_end = cnt >= div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= 1'b0;
    end else if (wr_ctl) begin
      div_q <= reg_wdata[DIV_W-1:0];
      pre_q <= reg_wdata[DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      busy  <= 1'b0;
      fpre  <= 1'b0;
      fread <= 1'b0;
      bidx  <= '0;
      cnt   <= '0;
      mdc_q <= 1'b0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!busy) begin
      if (wr_cmd) begin
        cmd   <= reg_wdata;
        busy  <= 1'b1;
        fpre  <= pre_q;
        fread <= reg_wdata[29:28] == 2'b10;
        bidx  <= '0;
        cnt   <= '0;
        mdc_q <= 1'b0;
        out_q <= pre_q ? 1'b1 : reg_wdata[31];
        oe_q  <= 1'b1;
      end
    end else if (!half_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (csamp) cmd[5'd31 - cpos[4:0]] <= mdio_i;
      end else begin
        mdc_q <= 1'b0;
        if (bidx == last_idx) begin
          busy <= 1'b0;
          oe_q <= 1'b0;
        end else begin
          bidx  <= nidx;
          out_q <= nval;
          oe_q  <= ndrv;
        end
      end
    end
  end

  wire done = busy && half_end && mdc_q && bidx == last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     irq_q <= 1'b0;
    else if (done)                  irq_q <= 1'b1;
    else if (wr_sts && reg_wdata[0]) irq_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(31-DIV_W){1'b0}}, pre_q, div_q};
      2'd1:    reg_rdata = cmd;
      2'd2:    reg_rdata = {31'd0, irq_q};
      default: reg_rdata = '0;
    endcase
  end

  assign mdc     = mdc_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign irq     = irq_q;

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
  a_r5_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc_q && $past(mdc_q) && $past(busy)) |-> $stable(mdio_o));
  a_r8_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(busy));
  a_r8_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_q);
  a_r6_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fread && !cpre && cpos >= IW'(TA_POS)) |-> !mdio_oe);
  a_r7_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fread) |-> mdio_oe);
  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(wr_cmd)) |-> $stable(cmd[31:16]));
endmodule

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, mdio_i = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;

  int n_chk = 0, n_bad = 0;
  int nrise = 0, nfall = 0;
  bit phy_pre = 1'b0;
  logic [15:0] phy_rdv = '0;
  logic [63:0] rec_o = '0, rec_oe = '0;

  always #(PERIOD/2) clk = ~clk;

  mdio_cmd_master uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  always @(posedge mdc) begin
    if (nrise < 64) begin
      rec_o[nrise]  = mdio_o;
      rec_oe[nrise] = mdio_oe;
    end
    nrise++;
  end

  always @(negedge mdc) begin
    int q;
    nfall++;
    q = nfall - (phy_pre ? 32 : 0);
    if (q >= 16 && q <= 31) mdio_i = phy_rdv[31-q];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_frame(input int div, input bit pre, input logic [31:0] c,
                           input logic [15:0] rdv, input bit interfere);
    int cycles, n;
    bit rd;
    logic [63:0] exp_o, exp_oe;
    logic [31:0] rb, exp_rb;
    bus_wr(2'd0, {24'd0, pre, 7'(div)});
    bus_wr(2'd2, 32'd1);
    phy_rdv = rdv; phy_pre = pre; nrise = 0; nfall = 0; mdio_i = 1'b1;
    rec_o = '0; rec_oe = '0;
    bus_wr(2'd1, c);
    cycles = 0;
    while (!irq && cycles < 20000) begin
      @(negedge clk); cycles++;
      if (interfere && cycles == 40) begin
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = ~c;
        @(negedge clk); cycles++;
        reg_we = 1'b0;
      end
    end
    n = pre ? 64 : 32;
    rd = c[29:28] == 2'b10;
    exp_o = '0; exp_oe = '0;
    for (int i = 0; i < n; i++) begin
      int p;
      p = i - (pre ? 32 : 0);
      if (p < 0) begin exp_o[i] = 1'b1; exp_oe[i] = 1'b1; end
      else begin
        exp_oe[i] = !(rd && p >= 14);
        exp_o[i]  = exp_oe[i] ? c[31-p] : 1'b0;
      end
    end
    check(cycles == 2*n*(div+1), "R5 completion cycle", 64'(cycles), 64'(2*n*(div+1)));
    check(nrise == n, "R4 mdc period count", 64'(nrise), 64'(n));
    check((rec_o & exp_oe) == exp_o, "R3 frame bits", rec_o & exp_oe, exp_o);
    check(rec_oe == exp_oe, rd ? "R6 read drive pattern" : "R7 write drive pattern", rec_oe, exp_oe);
    bus_rd(2'd1, rb);
    exp_rb = rd ? {c[31:16], rdv} : c;
    check(rb == exp_rb, interfere ? "R10 command unchanged" : "R6 readback", 64'(rb), 64'(exp_rb));
    @(negedge clk);
    check(!mdc && !mdio_oe, "R9 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    check(irq == 1'b1, "R11 irq pin", 64'(irq), 64'd1);
  endtask

  initial begin
    #(PERIOD*190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check(!mdc && !mdio_oe && !irq, "R1 reset outputs", {61'd0, mdc, mdio_oe, irq}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), v);
      check(v == 32'd0, "R1 reset registers", 64'(v), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    bus_wr(2'd0, 32'h0000_009F);
    bus_rd(2'd0, v);
    check(v == 32'h9F, "R2 control readback", 64'(v), 64'h9F);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_rd(2'd3, v);
    check(v == 32'd0, "R2 unused offset", 64'(v), 64'd0);

    for (int div = 0; div < 4; div++)
      for (int pre = 0; pre < 2; pre++)
        for (int rdop = 0; rdop < 2; rdop++) begin
          logic [31:0] c;
          logic [4:0] phy, rg;
          logic [15:0] dat;
          phy = 5'(div*7 + pre*3 + rdop + 1);
          rg  = 5'(31 - div*5 - pre*2 - rdop);
          dat = 16'hA5C3 ^ 16'(div*16'h1111 + pre*16'h0F0F + rdop*16'h8001);
          c = {rdop ? 4'h6 : 4'h5, phy, rg, 2'b10, dat};
          run_frame(div, pre[0], c, ~dat, 1'b0);
        end

    run_frame(1, 1'b0, {4'h5, 5'd9, 5'd4, 2'b10, 16'h1234}, 16'h0, 1'b1);
    run_frame(0, 1'b1, {4'h6, 5'd2, 5'd17, 2'b10, 16'h0000}, 16'hBEEF, 1'b1);

    bus_wr(2'd2, 32'd0);
    bus_rd(2'd2, v);
    check(v == 32'd1 && irq, "R8 write zero keeps flag", 64'(v), 64'd1);
    bus_wr(2'd2, 32'd1);
    bus_rd(2'd2, v);
    check(v == 32'd0 && !irq, "R8 write one clears flag", 64'(v), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule